// File: doc/BRIEF.md
# Controller Configuration and Status Register Block

This block is the register file of a host-attached storage controller. It also runs the controller's enable and shutdown sequence. Host software reaches it through a 32-bit read/write port addressed by byte offset.

The block holds:
- two read-only words: the controller capability and the interface version;
- an interrupt mask, changed through a set offset and a clear offset;
- a configuration word with the enable bit, memory page size, I/O entry sizes and shutdown request field;
- the admin queue size attributes;
- two 64-bit admin queue base addresses, each written as a low half and a high half.

When a configuration write raises enable, the block checks the page size, the entry sizes, the admin queue sizes and the alignment of both admin bases. It then reports either ready or fatal in the status word. When enable falls, or when a shutdown is requested, the block pulses `queue_reset` for one cycle so that the queue engines drop their state. A shutdown request also sets a shutdown-complete status bit.

The enable sequencer has four states:
- `SEQ_OFF`: disabled, no fault.
- `SEQ_RUN`: enabled and ready.
- `SEQ_FAULT`: enabled, but validation failed.
- `SEQ_OFF_FAULT`: disabled, with the fault still reported.

Its transitions are:
- `T_START_OK`: OFF or OFF_FAULT to RUN.
- `T_START_BAD`: OFF or OFF_FAULT to FAULT.
- `T_STOP`: RUN to OFF.
- `T_STOP_FAULT`: FAULT to OFF_FAULT.

Top module: `ctrl_cfg_status`

## Requirements
- R1: After reset:
  - configuration (0x14), status (0x1C), interrupt mask, attributes (0x24) and all base halves read 0;
  - offset 0x00 reads 0x0F0307FF: entry limit 0x7FF in bits 15:0, contiguous-queue bit 16, arbitration bit 17, timeout 0x0F in bits 31:24;
  - offset 0x04 reads 0x00400020: command set bit 5, minimum page exponent 0 in bits 19:16, maximum page exponent 4 in bits 23:20;
  - offset 0x08 reads 0x00010100.
- R2: A write to 0x0C ORs the data into the interrupt mask. Offsets 0x0C and 0x10 both read the mask.
- R3: A write to 0x10 clears the mask bits that are 1 in the data.
- R4: Configuration fields are:
  - enable: bit 0;
  - page exponent MPS: bits 10:7;
  - shutdown request: bits 15:14;
  - submission entry size (log2): bits 19:16;
  - completion entry size (log2): bits 23:20.

  A configuration write is stored as-is when enable and shutdown request are zero in both the old and new values. A write that matches neither that case nor an enable or shutdown edge leaves configuration and status unchanged.
- R5: A write that raises enable stores the data. If validation passes, the status becomes exactly 0x1 (ready bit 0), which also clears any earlier fault or shutdown-complete bit.
- R6: Validation fails if any of these holds:
  - either admin base is zero;
  - either admin base is not aligned to 4096<<MPS bytes;
  - MPS is greater than 4;
  - the submission size is not 6;
  - the completion size is not 4;
  - the attributes field bits 11:0 is zero;
  - the attributes field bits 27:16 is zero.

  On failure the data is still stored and the status becomes exactly 0x2 (fatal bit 1).
- R7: A write that drops enable pulses `queue_reset`, clears the ready bit, keeps the fatal bit, and resets the configuration to zero.
- R8: A write whose shutdown field goes from zero to nonzero pulses `queue_reset`, stores the data and sets shutdown-complete (status bit 3). This includes the case where the same write drops enable; the edge is then judged against the cleared configuration.
- R9: A write whose shutdown field goes from nonzero to zero, with no enable rise, stores the data and clears shutdown-complete without pulsing `queue_reset`.
- R10: Offset 0x24 stores and returns all 32 bits of the admin queue attributes.
- R11: Writing 0x28 (or 0x30) loads the submission (or completion) base with the data in the low half and zero in the high half. Writing 0x2C (or 0x34) ORs the data into the high half. Each half reads back at its own offset.
- R12: Reads of unlisted offsets, including 0x18 and anything at 0x38 or above, return zero. Writes to unlisted or read-only offsets (0x00, 0x04, 0x08, 0x1C, 0x18, 0x40) change nothing.
- R13: `rdata` carries the word addressed in a cycle with `rd_en` high from the next cycle on, and holds while `rd_en` is low.
- R14: `queue_reset` is high for exactly one cycle after each configuration write that clears queues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| queue_reset | output | 1 | One-cycle pulse telling queue engines to drop all queues |

## Verification
A single configuration write can drop enable and raise the shutdown request together. This makes the disable path and the shutdown path act in the same cycle. The bench provokes it by writing enable 0 with a nonzero shutdown field while the controller is running. The expected outcome is:
- exactly one `queue_reset` pulse;
- ready cleared;
- shutdown-complete set;
- the written value kept as the configuration.

The bench also sweeps page exponents against base alignments, and every entry-size code. The pass/fatal outcome of each case is predicted arithmetically.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    // Register byte offsets: host software decodes these, so they are fixed.
    localparam int unsigned OFF_CAP_LO = 32'h00;
    localparam int unsigned OFF_CAP_HI = 32'h04;
    localparam int unsigned OFF_VER    = 32'h08;
    localparam int unsigned OFF_MSET   = 32'h0C;
    localparam int unsigned OFF_MCLR   = 32'h10;
    localparam int unsigned OFF_CFG    = 32'h14;
    localparam int unsigned OFF_STAT   = 32'h1C;
    localparam int unsigned OFF_AQA    = 32'h24;
    localparam int unsigned OFF_ASQ_LO = 32'h28;
    localparam int unsigned OFF_ASQ_HI = 32'h2C;
    localparam int unsigned OFF_ACQ_LO = 32'h30;
    localparam int unsigned OFF_ACQ_HI = 32'h34;

    // Configuration field positions
    localparam int CFG_EN       = 0;
    localparam int CFG_MPS_LSB  = 7;
    localparam int CFG_SHN_LSB  = 14;
    localparam int CFG_SQES_LSB = 16;
    localparam int CFG_CQES_LSB = 20;

    // Status bit positions
    localparam int STAT_RDY   = 0;
    localparam int STAT_FAULT = 1;
    localparam int STAT_SHDN  = 3;

    typedef enum logic [1:0] {
        SEQ_OFF       = 2'd0,
        SEQ_RUN       = 2'd1,
        SEQ_FAULT     = 2'd2,
        SEQ_OFF_FAULT = 2'd3
    } seq_state_e;

    function automatic logic cfg_en(input logic [31:0] w);
        return w[CFG_EN];
    endfunction

    function automatic logic [1:0] cfg_shn(input logic [31:0] w);
        return w[CFG_SHN_LSB +: 2];
    endfunction

    function automatic logic [3:0] cfg_mps(input logic [31:0] w);
        return w[CFG_MPS_LSB +: 4];
    endfunction

    function automatic logic [3:0] cfg_sqes(input logic [31:0] w);
        return w[CFG_SQES_LSB +: 4];
    endfunction

    function automatic logic [3:0] cfg_cqes(input logic [31:0] w);
        return w[CFG_CQES_LSB +: 4];
    endfunction

endpackage

// File: rtl/ccr_validate.sv
module ccr_validate
    import ccr_pkg::*;
#(
    parameter int MPS_MIN   = 0,
    parameter int MPS_MAX   = 4,
    parameter int SQES_REQ  = 6,
    parameter int CQES_REQ  = 4,
    parameter int PAGE_BASE = 12
) (
    input  logic [31:0] cfg_new,
    input  logic [31:0] aqa,
    input  logic [63:0] asq_base,
    input  logic [63:0] acq_base,
    output logic        ok
);

    logic [3:0]  mps;
    logic [63:0] page_mask;
    logic        bad_asq;
    logic        bad_acq;
    logic        bad_mps;
    logic        bad_sizes;
    logic        bad_aqa;

    always_comb begin
        mps       = cfg_mps(cfg_new);
        // Low (PAGE_BASE + MPS) bits set: any of them set in a base means misaligned.
        page_mask = (64'd1 << (PAGE_BASE + int'(mps))) - 64'd1;
        bad_asq   = (asq_base == 64'd0) || ((asq_base & page_mask) != 64'd0);
        bad_acq   = (acq_base == 64'd0) || ((acq_base & page_mask) != 64'd0);
        bad_mps   = (int'(mps) < MPS_MIN) || (int'(mps) > MPS_MAX);
        bad_sizes = (int'(cfg_sqes(cfg_new)) != SQES_REQ) ||
                    (int'(cfg_cqes(cfg_new)) != CQES_REQ);
        bad_aqa   = (aqa[11:0] == 12'd0) || (aqa[27:16] == 12'd0);
        ok        = !(bad_asq || bad_acq || bad_mps || bad_sizes || bad_aqa);
    end

endmodule

// File: rtl/ccr_seq.sv
module ccr_seq
    import ccr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] wdata,
    input  logic        start_ok,
    output logic [31:0] cfg_q,
    output logic [31:0] status,
    output logic        queue_reset
);

    seq_state_e  state_q, state_d;
    logic [31:0] cfg_d;
    logic [31:0] held;
    logic        shst_q, shst_d;
    logic        clr;
    logic        new_en, old_en;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    // Next-state and write decisions
    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        shst_d  = shst_q;
        clr     = 1'b0;
        held    = cfg_q;
        new_en  = cfg_en(wdata);
        old_en  = cfg_en(cfg_q);
        if (cfg_wr) begin
            // Quiet store: enable and shutdown request idle in old and new value.
            if (!new_en && !old_en && cfg_shn(wdata) == 2'b00 && cfg_shn(cfg_q) == 2'b00)
                cfg_d = wdata;
            if (new_en && !old_en) begin
                // Enable rise: store, validate, overwrite status.
                cfg_d  = wdata;
                shst_d = 1'b0;
                unique case (state_q)
                    SEQ_OFF, SEQ_OFF_FAULT: state_d = start_ok ? SEQ_RUN : SEQ_FAULT;
                    default:                state_d = state_q;
                endcase
            end else begin
                if (!new_en && old_en) begin
                    // Enable fall: clear queues and configuration.
                    clr   = 1'b1;
                    held  = '0;
                    cfg_d = '0;
                    unique case (state_q)
                        SEQ_RUN:   state_d = SEQ_OFF;
                        SEQ_FAULT: state_d = SEQ_OFF_FAULT;
                        default:   state_d = state_q;
                    endcase
                end
                // Shutdown edges are judged against the value left after any disable.
                if (cfg_shn(wdata) != 2'b00 && cfg_shn(held) == 2'b00) begin
                    clr    = 1'b1;
                    cfg_d  = wdata;
                    shst_d = 1'b1;
                end else if (cfg_shn(wdata) == 2'b00 && cfg_shn(held) != 2'b00) begin
                    cfg_d  = wdata;
                    shst_d = 1'b0;
                end
            end
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            shst_q      <= 1'b0;
            queue_reset <= 1'b0;
        end else begin
            cfg_q       <= cfg_d;
            shst_q      <= shst_d;
            queue_reset <= clr;
        end
    end

    always_comb begin
        status             = '0;
        status[STAT_RDY]   = (state_q == SEQ_RUN);
        status[STAT_FAULT] = (state_q == SEQ_FAULT) || (state_q == SEQ_OFF_FAULT);
        status[STAT_SHDN]  = shst_q;
    end

    // R5: enabled states line up with the stored enable bit
    a_r5_state_tracks_enable: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CFG_EN] == (state_q == SEQ_RUN || state_q == SEQ_FAULT));

    // R6: a failed start lands in the fault state
    a_r6_bad_start_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_en(wdata) && !cfg_en(cfg_q) && !start_ok) |=> (state_q == SEQ_FAULT));

    // R14: a queue reset pulse always follows a configuration write
    a_r14_qreset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        queue_reset |-> $past(cfg_wr));

    // R8: shutdown-complete rises only after a write requesting shutdown
    a_r8_shdn_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shst_q) |-> $past(cfg_wr && cfg_shn(wdata) != 2'b00));

endmodule

// File: rtl/ccr_readmux.sv
module ccr_readmux
    import ccr_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [31:0] CAP_LO = 32'h0,
    parameter logic [31:0] CAP_HI = 32'h0,
    parameter logic [31:0] VER    = 32'h0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       cfg,
    input  logic [31:0]       status,
    input  logic [31:0]       mask,
    input  logic [31:0]       aqa,
    input  logic [63:0]       asq_base,
    input  logic [63:0]       acq_base,
    output logic [31:0]       word
);

    always_comb begin
        case (addr)
            ADDR_W'(OFF_CAP_LO): word = CAP_LO;
            ADDR_W'(OFF_CAP_HI): word = CAP_HI;
            ADDR_W'(OFF_VER):    word = VER;
            ADDR_W'(OFF_MSET):   word = mask;
            ADDR_W'(OFF_MCLR):   word = mask;
            ADDR_W'(OFF_CFG):    word = cfg;
            ADDR_W'(OFF_STAT):   word = status;
            ADDR_W'(OFF_AQA):    word = aqa;
            ADDR_W'(OFF_ASQ_LO): word = asq_base[31:0];
            ADDR_W'(OFF_ASQ_HI): word = asq_base[63:32];
            ADDR_W'(OFF_ACQ_LO): word = acq_base[31:0];
            ADDR_W'(OFF_ACQ_HI): word = acq_base[63:32];
            default:             word = '0;
        endcase
    end

endmodule

// File: rtl/ctrl_cfg_status.sv
module ctrl_cfg_status
    import ccr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [15:0] MQES      = 16'h07FF,
    parameter logic [7:0]  TIMEOUT   = 8'h0F,
    parameter int          MPS_MIN   = 0,
    parameter int          MPS_MAX   = 4,
    parameter int          SQES_REQ  = 6,
    parameter int          CQES_REQ  = 4,
    parameter int          PAGE_BASE = 12,
    parameter logic [31:0] VERSION   = 32'h0001_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              queue_reset
);

    // Capability words: contiguous-queue and arbitration bits set, command set 1.
    localparam logic [31:0] CAP_LO = {TIMEOUT, 5'b0, 2'b01, 1'b1, MQES};
    localparam logic [31:0] CAP_HI = {8'h00, 4'(MPS_MAX), 4'(MPS_MIN), 3'b0, 8'h01, 5'b0};

    logic [31:0] mask_q;
    logic [31:0] aqa_q;
    logic [63:0] asq_q;
    logic [63:0] acq_q;
    logic [31:0] cfg_q;
    logic [31:0] status;
    logic [31:0] rd_word;
    logic        start_ok;
    logic        set_wr, clr_wr, cfg_wr, aqa_wr;
    logic        asq_lo_wr, asq_hi_wr, acq_lo_wr, acq_hi_wr;

    always_comb begin
        set_wr    = wr_en && (addr == ADDR_W'(OFF_MSET));
        clr_wr    = wr_en && (addr == ADDR_W'(OFF_MCLR));
        cfg_wr    = wr_en && (addr == ADDR_W'(OFF_CFG));
        aqa_wr    = wr_en && (addr == ADDR_W'(OFF_AQA));
        asq_lo_wr = wr_en && (addr == ADDR_W'(OFF_ASQ_LO));
        asq_hi_wr = wr_en && (addr == ADDR_W'(OFF_ASQ_HI));
        acq_lo_wr = wr_en && (addr == ADDR_W'(OFF_ACQ_LO));
        acq_hi_wr = wr_en && (addr == ADDR_W'(OFF_ACQ_HI));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            aqa_q  <= '0;
            asq_q  <= '0;
            acq_q  <= '0;
            rdata  <= '0;
        end else begin
            if (set_wr)    mask_q <= mask_q | wdata;
            if (clr_wr)    mask_q <= mask_q & ~wdata;
            if (aqa_wr)    aqa_q  <= wdata;
            // Low-half write loads the whole base; high-half write merges in.
            if (asq_lo_wr) asq_q  <= {32'h0, wdata};
            if (asq_hi_wr) asq_q  <= asq_q | {wdata, 32'h0};
            if (acq_lo_wr) acq_q  <= {32'h0, wdata};
            if (acq_hi_wr) acq_q  <= acq_q | {wdata, 32'h0};
            if (rd_en)     rdata  <= rd_word;
        end
    end

    ccr_validate #(
        .MPS_MIN(MPS_MIN), .MPS_MAX(MPS_MAX), .SQES_REQ(SQES_REQ),
        .CQES_REQ(CQES_REQ), .PAGE_BASE(PAGE_BASE)
    ) u_validate (
        .cfg_new(wdata), .aqa(aqa_q), .asq_base(asq_q), .acq_base(acq_q), .ok(start_ok)
    );

    ccr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wdata(wdata), .start_ok(start_ok),
        .cfg_q(cfg_q), .status(status), .queue_reset(queue_reset)
    );

    ccr_readmux #(
        .ADDR_W(ADDR_W), .CAP_LO(CAP_LO), .CAP_HI(CAP_HI), .VER(VERSION)
    ) u_readmux (
        .addr(addr), .cfg(cfg_q), .status(status), .mask(mask_q), .aqa(aqa_q),
        .asq_base(asq_q), .acq_base(acq_q), .word(rd_word)
    );

    // R2: every bit written to the set offset is present afterwards
    a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R3: every bit written to the clear offset is gone afterwards
    a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((mask_q & $past(wdata)) == 32'h0));

    // R11: a low-half base write leaves the high half zero
    a_r11_asq_low_zeroes_high: assert property (@(posedge clk) disable iff (!rst_n)
        asq_lo_wr |=> (asq_q[63:32] == 32'h0));

    // R13: read data holds when no read is issued
    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/tb_ctrl_cfg_status.sv
`timescale 1ns/1ps
module tb_ctrl_cfg_status;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              queue_reset;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ctrl_cfg_status dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .queue_reset(queue_reset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rdchk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Configuration word from fields
    function automatic logic [31:0] mkcfg(input bit en, input int mps, input int shn,
                                          input int sqes, input int cqes);
        return 32'(en) | (32'(mps) << 7) | (32'(shn) << 14) | (32'(sqes) << 16) | (32'(cqes) << 20);
    endfunction

    // Write configuration and check the queue reset pulse width
    task automatic cfgwr(input string req, input logic [31:0] d, input bit exp_qr);
        wr(32'h14, d);
        chk(req, 32'(queue_reset), 32'(exp_qr));
        @(negedge clk);
        chk("R14 pulse ends", 32'(queue_reset), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R14 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, m, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values and constants
        rdchk("R1 cap lo", 32'h00, 32'h0F0307FF);
        rdchk("R1 cap hi", 32'h04, 32'h00400020);
        rdchk("R1 version", 32'h08, 32'h00010100);
        rdchk("R1 cfg", 32'h14, 32'h0);
        rdchk("R1 status", 32'h1C, 32'h0);
        rdchk("R1 mask", 32'h0C, 32'h0);
        rdchk("R1 aqa", 32'h24, 32'h0);
        rdchk("R1 asq hi", 32'h2C, 32'h0);
        chk("R1 queue_reset", 32'(queue_reset), 32'h0);

        // R12 unlisted reads
        rdchk("R12 gap 0x18", 32'h18, 32'h0);
        rdchk("R12 0x38", 32'h38, 32'h0);
        rdchk("R12 0xFFC", 32'hFFC, 32'h0);

        // R13 hold while idle
        rd(32'h08, v);
        @(negedge clk); addr = ADDR_W'(32'h00);
        repeat (3) @(negedge clk);
        chk("R13 rdata holds", rdata, 32'h00010100);

        // R2 / R3 mask sweep
        m = 32'h0;
        for (int i = 0; i < 8; i++) begin
            wr(32'h0C, 32'h3 << (i * 4));
            m = m | (32'h3 << (i * 4));
            rdchk("R2 mask at set", 32'h0C, m);
            rdchk("R2 mask at clear", 32'h10, m);
        end
        for (int i = 0; i < 8; i++) begin
            wr(32'h10, 32'h1 << (i * 4));
            m = m & ~(32'h1 << (i * 4));
            rdchk("R3 mask cleared", 32'h0C, m);
        end

        // R12 ignored writes
        wr(32'h00, 32'hFFFFFFFF); wr(32'h08, 32'hFFFFFFFF);
        wr(32'h1C, 32'hFFFFFFFF); wr(32'h18, 32'hFFFFFFFF); wr(32'h40, 32'hFFFFFFFF);
        rdchk("R12 cap kept", 32'h00, 32'h0F0307FF);
        rdchk("R12 version kept", 32'h08, 32'h00010100);
        rdchk("R12 status kept", 32'h1C, 32'h0);
        rdchk("R12 gap still zero", 32'h18, 32'h0);
        rdchk("R12 mask kept", 32'h0C, m);

        // R10 attributes
        wr(32'h24, 32'hA5A5_5A5A);
        rdchk("R10 aqa", 32'h24, 32'hA5A5_5A5A);
        wr(32'h24, 32'h001F_003F);
        rdchk("R10 aqa", 32'h24, 32'h001F_003F);

        // R11 base halves
        wr(32'h2C, 32'h1);
        rdchk("R11 hi only", 32'h2C, 32'h1);
        wr(32'h28, 32'h2000);
        rdchk("R11 low clears hi", 32'h2C, 32'h0);
        rdchk("R11 low value", 32'h28, 32'h2000);
        wr(32'h2C, 32'h4); wr(32'h2C, 32'h1);
        rdchk("R11 hi merges", 32'h2C, 32'h5);
        wr(32'h34, 32'h2); wr(32'h30, 32'h0010_0000);
        rdchk("R11 acq hi cleared", 32'h34, 32'h0);
        rdchk("R11 acq low", 32'h30, 32'h0010_0000);

        // R4 direct store when idle
        cfgwr("R4 quiet store", mkcfg(0, 2, 0, 6, 4), 1'b0);
        rdchk("R4 cfg stored", 32'h14, mkcfg(0, 2, 0, 6, 4));
        cfgwr("R4 quiet store", 32'h00F0_0380, 1'b0);
        rdchk("R4 cfg stored", 32'h14, 32'h00F0_0380);

        // R5 / R6 / R7 sweep: page exponent versus base alignment
        wr(32'h30, 32'h0010_0000);
        for (int mps = 0; mps < 7; mps++) begin
            for (int k = 12; k <= 20; k++) begin
                bit ok;
                logic [31:0] d;
                wr(32'h28, 32'h1 << k);
                ok = (mps <= 4) && (k >= 12 + mps);
                d = mkcfg(1, mps, 0, 6, 4);
                cfgwr("R5 no reset on start", d, 1'b0);
                rdchk(ok ? "R5 ready" : "R6 fatal align/mps", 32'h1C, ok ? 32'h1 : 32'h2);
                rdchk("R5 cfg stored", 32'h14, d);
                cfgwr("R7 disable pulses reset", 32'h0, 1'b1);
                rdchk("R7 ready dropped", 32'h1C, ok ? 32'h0 : 32'h2);
                rdchk("R7 cfg cleared", 32'h14, 32'h0);
            end
        end

        // R6 entry-size codes
        wr(32'h28, 32'h0001_0000);
        for (int s = 0; s < 16; s++) begin
            cfgwr("R6 start", mkcfg(1, 0, 0, s, 4), 1'b0);
            rdchk("R6 sq size", 32'h1C, (s == 6) ? 32'h1 : 32'h2);
            cfgwr("R7 stop", 32'h0, 1'b1);
        end
        for (int s = 0; s < 16; s++) begin
            cfgwr("R6 start", mkcfg(1, 0, 0, 6, s), 1'b0);
            rdchk("R6 cq size", 32'h1C, (s == 4) ? 32'h1 : 32'h2);
            cfgwr("R7 stop", 32'h0, 1'b1);
        end

        // R6 zero attribute fields and zero bases
        wr(32'h24, 32'h001F_0000);
        cfgwr("R6 start", mkcfg(1, 0, 0, 6, 4), 1'b0);
        rdchk("R6 sq count zero", 32'h1C, 32'h2);
        cfgwr("R7 stop", 32'h0, 1'b1);
        wr(32'h24, 32'h0000_001F);
        cfgwr("R6 start", mkcfg(1, 0, 0, 6, 4), 1'b0);
        rdchk("R6 cq count zero", 32'h1C, 32'h2);
        cfgwr("R7 stop", 32'h0, 1'b1);
        wr(32'h24, 32'h001F_001F);
        wr(32'h28, 32'h0);
        cfgwr("R6 start", mkcfg(1, 0, 0, 6, 4), 1'b0);
        rdchk("R6 sq base zero", 32'h1C, 32'h2);
        cfgwr("R7 stop", 32'h0, 1'b1);
        wr(32'h28, 32'h0001_0000); wr(32'h30, 32'h0);
        cfgwr("R6 start", mkcfg(1, 0, 0, 6, 4), 1'b0);
        rdchk("R6 cq base zero", 32'h1C, 32'h2);
        cfgwr("R7 stop", 32'h0, 1'b1);
        wr(32'h30, 32'h0002_0000);

        // R5 start clears fault; R4 writes while running ignored
        cfgwr("R5 start", mkcfg(1, 0, 0, 6, 4), 1'b0);
        rdchk("R5 fault cleared by good start", 32'h1C, 32'h1);
        cfgwr("R4 ignored while running", mkcfg(1, 3, 0, 6, 4), 1'b0);
        rdchk("R4 cfg unchanged", 32'h14, mkcfg(1, 0, 0, 6, 4));
        rdchk("R4 status unchanged", 32'h1C, 32'h1);

        // R8 / R9 shutdown while running
        cfgwr("R8 shutdown pulses reset", mkcfg(1, 0, 1, 6, 4), 1'b1);
        rdchk("R8 shutdown complete", 32'h1C, 32'h9);
        rdchk("R8 cfg stored", 32'h14, mkcfg(1, 0, 1, 6, 4));
        cfgwr("R9 no reset on release", mkcfg(1, 0, 0, 6, 4), 1'b0);
        rdchk("R9 shutdown cleared", 32'h1C, 32'h1);
        rdchk("R9 cfg stored", 32'h14, mkcfg(1, 0, 0, 6, 4));

        // R8 combined disable + shutdown in one write
        held = mkcfg(0, 0, 2, 6, 4);
        cfgwr("R8 combined single pulse", held, 1'b1);
        rdchk("R8 combined status", 32'h1C, 32'h8);
        rdchk("R8 combined cfg", 32'h14, held);
        cfgwr("R9 release from off", 32'h0, 1'b0);
        rdchk("R9 status off", 32'h1C, 32'h0);
        rdchk("R9 cfg cleared", 32'h14, 32'h0);

        // R8 shutdown from off, then a start clears shutdown-complete
        cfgwr("R8 shutdown from off", mkcfg(0, 0, 1, 6, 4), 1'b1);
        rdchk("R8 status", 32'h1C, 32'h8);
        cfgwr("R5 start after shutdown", mkcfg(1, 0, 0, 6, 4), 1'b0);
        rdchk("R5 status overwritten", 32'h1C, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule